// File: doc/BRIEF.md
# USB Device Mode and Hardware Configuration Register Block

This block holds two configuration registers of a full-speed USB device controller. The first is a one-byte mode register. The second is a two-byte hardware configuration register. A local microcontroller reaches both through a byte stream. A byte flagged as a command selects a register and a direction. The data bytes that follow are written into that register, and for a read command the block returns bytes on a separate stream. Two-byte registers always move low byte first.

Most register fields leave the block as plain control outputs:
- the DMA bus width;
- the interrupt-policy select for the endpoint logic;
- the clock division factor;
- the gated soft-connect pull-up enable.

The block also turns a particular write sequence on the suspend-request bit into a single-cycle suspend pulse. It gates the pending interrupt sources with a global enable.

Both streams use valid/ready. The input side is always ready, so `in_ready` is tied high and no input byte is ever stalled. The read side holds `rd_valid` and `rd_data` steady until `rd_ready` accepts the byte. A new command drops any byte still offered.

Top module: `devcfg_regs`

## Requirements
- R1: Command 0xB8 followed by one data byte writes the mode register, and command 0xB9 offers it as one byte on the read stream. The mode register fields are:
  - bit 7: DMA width (1 = 16-bit);
  - bit 5: suspend request;
  - bit 3: global interrupt enable;
  - bit 2: debug interrupt policy;
  - bit 0: soft-connect.
  Bits 6, 4 and 1 are reserved: they always hold 0 and read back as 0.
- R2: Command 0xBA followed by two data bytes, low byte first, writes the hardware configuration register. The register changes only on the edge that accepts the second byte, so no half-written value is ever visible. Command 0xBB offers the low byte first and then the high byte.
- R3: `suspend_pulse` is high for exactly one cycle, in the cycle after a mode write. It fires when that write clears bit 5 while the register held bit 5 = 1. A write that leaves bit 5 at 1, or keeps it at 0, gives no pulse.
- R4: Power-on reset (`rst_n` low) clears both registers to 0. The USB bus reset input has no effect on either register or on any output.
- R5: `soft_connect` is high only when mode bit 0 is 1 and bit 2 of the low hardware configuration byte (external pull-up select) is 0.
- R6: `irq_out` is high only when mode bit 3 is 1 and at least one bit of `irq_src` is high. This is combinational.
- R7: `irq_dbg_policy` follows mode bit 2, and `dma_wide` follows mode bit 7. `clk_div` follows bits 3:0 of the high hardware configuration byte.
- R8: The following data bytes are ignored and change no register:
  - a byte after reset, before any command;
  - a byte after an unknown command code;
  - a byte during a read command;
  - a byte beyond the current write command's byte count.
- R9: A command byte aborts any partly received two-byte write. The byte index restarts at 0 and the hardware configuration register stays unchanged.
- R10: `in_ready` is always 1. `rd_valid` rises in the cycle after a read command is accepted. While `rd_ready` is low and no command arrives, `rd_valid` and `rd_data` hold. Each accepted byte advances the index, and `rd_valid` drops after the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| usb_bus_reset | input | 1 | USB bus reset indication; deliberately leaves the registers alone |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte ready, always 1 |
| in_cmd | input | 1 | 1 = input byte is a command code, 0 = data byte |
| in_data | input | 8 | Input byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Read byte accepted |
| rd_data | output | 8 | Read byte |
| irq_src | input | N_IRQ | Pending interrupt sources |
| irq_out | output | 1 | Gated interrupt request |
| irq_dbg_policy | output | 1 | 1 = raise interrupts on NAK/error, 0 = on ACK/transfer |
| dma_wide | output | 1 | 1 = 16-bit DMA bus, 0 = 8-bit |
| soft_connect | output | 1 | Gated pull-up enable |
| suspend_pulse | output | 1 | One-cycle suspend request |
| mode_reg | output | 8 | Mode register contents |
| hw_cfg | output | 16 | Hardware configuration register contents |
| clk_div | output | 4 | Clock division factor |

## Verification
The assertions assume that `rst_n` is the only source of register change apart from accepted data bytes. They assume `rd_ready` may toggle freely while a read byte is offered, and that command and data bytes never arrive together. The latter holds because `in_cmd` selects one meaning per byte. The random stimulus draws commands from the four valid codes plus arbitrary codes, random data bytes, random `rd_ready`, random bus reset pulses and random interrupt sources. All of these are driven one byte per cycle on the falling edge. This keeps the input stream within the single-byte-per-cycle protocol the assertions depend on.

// File: rtl/devcfg_pkg.sv
package devcfg_pkg;

  localparam int BYTE_W = 8;
  localparam int IDX_W  = 2;

  localparam logic [BYTE_W-1:0] CMD_MODE_WR = 8'hB8;
  localparam logic [BYTE_W-1:0] CMD_MODE_RD = 8'hB9;
  localparam logic [BYTE_W-1:0] CMD_HW_WR   = 8'hBA;
  localparam logic [BYTE_W-1:0] CMD_HW_RD   = 8'hBB;

  localparam int MODE_BYTES = 1;
  localparam int HW_BYTES   = 2;

  // writable mode bits: 7, 5, 3, 2, 0
  localparam logic [BYTE_W-1:0] MODE_KEEP = 8'hAD;

  localparam int MB_DMA_WIDE = 7;
  localparam int MB_SUSPEND  = 5;
  localparam int MB_IRQ_EN   = 3;
  localparam int MB_DEBUG    = 2;
  localparam int MB_SOFTCON  = 0;

  localparam int HB_EXT_PULLUP = 2;
  localparam int HB_CLKDIV_LSB = 8;
  localparam int CLKDIV_W      = 4;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_MODE_WR = 3'd1,
    OP_MODE_RD = 3'd2,
    OP_HW_WR   = 3'd3,
    OP_HW_RD   = 3'd4
  } op_e;

  function automatic op_e op_decode(input logic [BYTE_W-1:0] code);
    case (code)
      CMD_MODE_WR: return OP_MODE_WR;
      CMD_MODE_RD: return OP_MODE_RD;
      CMD_HW_WR:   return OP_HW_WR;
      CMD_HW_RD:   return OP_HW_RD;
      default:     return OP_NONE;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] op_len(input op_e op);
    case (op)
      OP_MODE_WR, OP_MODE_RD: return IDX_W'(MODE_BYTES);
      OP_HW_WR, OP_HW_RD:     return IDX_W'(HW_BYTES);
      default:                return '0;
    endcase
  endfunction

  function automatic logic op_writes(input op_e op);
    return (op == OP_MODE_WR) || (op == OP_HW_WR);
  endfunction

  function automatic logic op_reads(input op_e op);
    return (op == OP_MODE_RD) || (op == OP_HW_RD);
  endfunction

endpackage

// File: rtl/devcfg_cmd_seq.sv
module devcfg_cmd_seq
  import devcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_cmd,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              rd_ready,
  output op_e               op_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              wr_mode_en,
  output logic              wr_hw_en,
  output logic              rd_valid
);

  logic             cmd_hit;
  logic             data_hit;
  logic             room;
  logic             rd_fire;
  logic [IDX_W-1:0] len;

  assign cmd_hit  = in_valid && in_cmd;
  assign data_hit = in_valid && !in_cmd;
  assign len      = op_len(op_q);
  assign room     = idx_q < len;

  assign wr_mode_en = data_hit && room && (op_q == OP_MODE_WR);
  assign wr_hw_en   = data_hit && room && (op_q == OP_HW_WR);
  assign rd_valid   = op_reads(op_q) && room;
  assign rd_fire    = rd_valid && rd_ready && !cmd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_NONE;
      idx_q <= '0;
    end else if (cmd_hit) begin
      op_q  <= op_decode(in_data);
      idx_q <= '0;
    end else if (wr_mode_en || wr_hw_en || rd_fire) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

endmodule

// File: rtl/devcfg_regfile.sv
module devcfg_regfile
  import devcfg_pkg::*;
#(
  parameter int                     NB    = 2,
  parameter logic [NB*BYTE_W-1:0]   WMASK = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [BYTE_W-1:0]    wr_data,
  output logic [NB*BYTE_W-1:0] value,
  output logic                 commit
);

  localparam int W = NB * BYTE_W;

  logic [W-1:0] value_q;
  logic [W-1:0] next_val;

  assign commit = wr_en && (wr_idx == IDX_W'(NB - 1));

  generate
    if (NB > 1) begin : g_stage
      logic [(NB-1)*BYTE_W-1:0] stage_q;
      for (genvar k = 0; k < NB - 1; k++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stage_q[k*BYTE_W +: BYTE_W] <= '0;
          end else if (wr_en && (wr_idx == IDX_W'(k))) begin
            stage_q[k*BYTE_W +: BYTE_W] <= wr_data;
          end
        end
      end
      assign next_val = {wr_data, stage_q};
    end else begin : g_single
      assign next_val = wr_data;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
    end else if (commit) begin
      value_q <= next_val & WMASK;
    end
  end

  assign value = value_q;

endmodule

// File: rtl/devcfg_suspend_det.sv
module devcfg_suspend_det (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic old_bit,
  input  logic new_bit,
  output logic pulse
);

  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= commit && old_bit && !new_bit;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/devcfg_ctrl_out.sv
module devcfg_ctrl_out
  import devcfg_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic [BYTE_W-1:0] mode,
  input  logic              ext_pullup,
  input  logic [N_IRQ-1:0]  irq_src,
  output logic              irq_out,
  output logic              irq_dbg_policy,
  output logic              dma_wide,
  output logic              soft_connect
);

  assign irq_out        = mode[MB_IRQ_EN] && (|irq_src);
  assign irq_dbg_policy = mode[MB_DEBUG];
  assign dma_wide       = mode[MB_DMA_WIDE];
  assign soft_connect   = mode[MB_SOFTCON] && !ext_pullup;

endmodule

// File: rtl/devcfg_regs.sv
module devcfg_regs
  import devcfg_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                usb_bus_reset,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_cmd,
  input  logic [BYTE_W-1:0]   in_data,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic [N_IRQ-1:0]    irq_src,
  output logic                irq_out,
  output logic                irq_dbg_policy,
  output logic                dma_wide,
  output logic                soft_connect,
  output logic                suspend_pulse,
  output logic [BYTE_W-1:0]   mode_reg,
  output logic [HW_BYTES*BYTE_W-1:0] hw_cfg,
  output logic [CLKDIV_W-1:0] clk_div
);

  op_e              op_q;
  logic [IDX_W-1:0] idx_q;
  logic             wr_mode_en;
  logic             wr_hw_en;
  logic             mode_commit;
  logic             hw_commit_unused;
  logic             bus_rst_unused;

  // bus reset is received but intentionally kept away from register state
  assign bus_rst_unused = usb_bus_reset;
  assign in_ready       = 1'b1;

  devcfg_cmd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_cmd     (in_cmd),
    .in_data    (in_data),
    .rd_ready   (rd_ready),
    .op_q       (op_q),
    .idx_q      (idx_q),
    .wr_mode_en (wr_mode_en),
    .wr_hw_en   (wr_hw_en),
    .rd_valid   (rd_valid)
  );

  devcfg_regfile #(
    .NB    (MODE_BYTES),
    .WMASK (MODE_KEEP)
  ) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_mode_en),
    .wr_idx  (idx_q),
    .wr_data (in_data),
    .value   (mode_reg),
    .commit  (mode_commit)
  );

  devcfg_regfile #(
    .NB    (HW_BYTES),
    .WMASK ('1)
  ) u_hw (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_hw_en),
    .wr_idx  (idx_q),
    .wr_data (in_data),
    .value   (hw_cfg),
    .commit  (hw_commit_unused)
  );

  devcfg_suspend_det u_susp (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (mode_commit),
    .old_bit (mode_reg[MB_SUSPEND]),
    .new_bit (in_data[MB_SUSPEND]),
    .pulse   (suspend_pulse)
  );

  devcfg_ctrl_out #(
    .N_IRQ (N_IRQ)
  ) u_ctrl (
    .mode           (mode_reg),
    .ext_pullup     (hw_cfg[HB_EXT_PULLUP]),
    .irq_src        (irq_src),
    .irq_out        (irq_out),
    .irq_dbg_policy (irq_dbg_policy),
    .dma_wide       (dma_wide),
    .soft_connect   (soft_connect)
  );

  assign clk_div = hw_cfg[HB_CLKDIV_LSB +: CLKDIV_W];

  always_comb begin
    rd_data = '0;
    if (rd_valid) begin
      if (op_q == OP_MODE_RD) begin
        rd_data = mode_reg;
      end else begin
        rd_data = hw_cfg[int'(idx_q)*BYTE_W +: BYTE_W];
      end
    end
  end

endmodule

// File: rtl/devcfg_regs_chk.sv
module devcfg_regs_chk #(
  parameter int N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             usb_bus_reset,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_cmd,
  input logic [7:0]       in_data,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [7:0]       rd_data,
  input logic [N_IRQ-1:0] irq_src,
  input logic             irq_out,
  input logic             irq_dbg_policy,
  input logic             dma_wide,
  input logic             soft_connect,
  input logic             suspend_pulse,
  input logic [7:0]       mode_reg,
  input logic [15:0]      hw_cfg,
  input logic [3:0]       clk_div
);

  // R1: reserved mode bits never hold a 1
  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_reg & 8'h52) == 8'h00);

  // R3: pulse lasts one cycle
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_pulse |=> !suspend_pulse);

  // R3: pulse only after the suspend bit went from 1 to 0
  a_r3_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_pulse |-> (!mode_reg[5] && $past(mode_reg[5])));

  // R2: hardware configuration only moves on an accepted data byte
  a_r2_moves_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && !in_cmd) |=> $stable(hw_cfg));

  // R4: bus reset without data leaves the mode register alone
  a_r4_bus_reset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_bus_reset && !(in_valid && !in_cmd)) |=> $stable(mode_reg));

  // R5: external pull-up overrides soft-connect
  a_r5_ext_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    hw_cfg[2] |-> !soft_connect);

  // R6: global interrupt enable gates the request
  a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_reg[3] |-> !irq_out);

  // R10: an offered read byte holds under back-pressure
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !(in_valid && in_cmd)) |=> (rd_valid && $stable(rd_data)));

endmodule

bind devcfg_regs devcfg_regs_chk #(.N_IRQ(N_IRQ)) u_chk (.*);

// File: tb/devcfg_regs_tb.sv
`timescale 1ns/1ps
module devcfg_regs_tb;

  localparam int N_IRQ = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             usb_bus_reset = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             in_cmd = 1'b0;
  logic [7:0]       in_data = 8'h00;
  logic             rd_valid;
  logic             rd_ready = 1'b0;
  logic [7:0]       rd_data;
  logic [N_IRQ-1:0] irq_src = '0;
  logic             irq_out;
  logic             irq_dbg_policy;
  logic             dma_wide;
  logic             soft_connect;
  logic             suspend_pulse;
  logic [7:0]       mode_reg;
  logic [15:0]      hw_cfg;
  logic [3:0]       clk_div;

  always #2.5 clk = ~clk;

  devcfg_regs #(.N_IRQ(N_IRQ)) u_dut (.*);

  int total = 0;
  int bad   = 0;

  // reference model, built from the requirements
  logic [7:0]  m_mode  = 8'h00;
  logic [15:0] m_hw    = 16'h0000;
  logic [7:0]  m_stage = 8'h00;
  int          m_op    = 0;   // 0 none, 1 mode wr, 2 mode rd, 3 hw wr, 4 hw rd
  int          m_idx   = 0;
  logic        m_susp  = 1'b0;

  function automatic int dec_op(input logic [7:0] c);
    case (c)
      8'hB8: return 1;
      8'hB9: return 2;
      8'hBA: return 3;
      8'hBB: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int op_cnt(input int op);
    if (op == 1 || op == 2) return 1;
    if (op == 3 || op == 4) return 2;
    return 0;
  endfunction

  function automatic logic exp_rdv();
    return (m_op == 2 || m_op == 4) && (m_idx < op_cnt(m_op));
  endfunction

  function automatic logic [7:0] exp_rdd();
    if (m_op == 2) return m_mode;
    return (m_idx == 0) ? m_hw[7:0] : m_hw[15:8];
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare(input string ctx);
    chk({ctx, " R1 mode_reg"}, {8'h00, mode_reg}, {8'h00, m_mode});
    chk({ctx, " R2 hw_cfg"}, hw_cfg, m_hw);
    chk({ctx, " R3 suspend_pulse"}, {15'd0, suspend_pulse}, {15'd0, m_susp});
    chk({ctx, " R5 soft_connect"}, {15'd0, soft_connect}, {15'd0, m_mode[0] & ~m_hw[2]});
    chk({ctx, " R6 irq_out"}, {15'd0, irq_out}, {15'd0, m_mode[3] & (|irq_src)});
    chk({ctx, " R7 policy/dma/clk_div"}, {10'd0, irq_dbg_policy, dma_wide, clk_div},
        {10'd0, m_mode[2], m_mode[7], m_hw[11:8]});
    chk({ctx, " R10 in_ready/rd_valid"}, {14'd0, in_ready, rd_valid}, {14'd0, 1'b1, exp_rdv()});
    if (exp_rdv()) chk({ctx, " R10 rd_data"}, {8'h00, rd_data}, {8'h00, exp_rdd()});
  endtask

  // one clock cycle: drive on the falling edge, model at the rising edge, check at the next falling edge
  task automatic cyc(input logic v, input logic c, input logic [7:0] d, input logic rr,
                     input logic br, input logic [N_IRQ-1:0] irq, input string ctx);
    logic fire;
    in_valid = v; in_cmd = c; in_data = d; rd_ready = rr; usb_bus_reset = br; irq_src = irq;
    @(posedge clk);
    fire   = exp_rdv() && rr && !(v && c);
    m_susp = 1'b0;
    if (v && c) begin
      m_op  = dec_op(d);
      m_idx = 0;
    end else if (v && m_idx < op_cnt(m_op) && m_op == 1) begin
      m_susp = m_mode[5] & ~d[5];
      m_mode = d & 8'hAD;
      m_idx++;
    end else if (v && m_idx < op_cnt(m_op) && m_op == 3) begin
      if (m_idx == 0) m_stage = d;
      else m_hw = {d, m_stage};
      m_idx++;
    end else if (fire) begin
      m_idx++;
    end
    @(negedge clk);
    compare(ctx);
  endtask

  task automatic cmd(input logic [7:0] code, input string ctx);
    cyc(1'b1, 1'b1, code, 1'b0, 1'b0, 8'h01, ctx);
  endtask

  task automatic dat(input logic [7:0] b, input string ctx);
    cyc(1'b1, 1'b0, b, 1'b0, 1'b0, 8'h01, ctx);
  endtask

  task automatic idle(input logic rr, input string ctx);
    cyc(1'b0, 1'b0, 8'h00, rr, 1'b0, 8'h01, ctx);
  endtask

  task automatic por(input string ctx);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    m_mode = 8'h00; m_hw = 16'h0000; m_stage = 8'h00;
    m_op = 0; m_idx = 0; m_susp = 1'b0;
    compare(ctx);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    @(negedge clk);
    @(negedge clk);
    compare("R4 reset");
    rst_n = 1'b1;

    // R8: data before any command
    dat(8'hFF, "R8 data no cmd");
    // R1: mode write masks reserved bits, then read back
    cmd(8'hB8, "R1 cmd");
    dat(8'hFF, "R1 write");
    dat(8'h00, "R8 beyond count");
    cmd(8'hB9, "R1 read cmd");
    idle(1'b1, "R1 read byte");
    idle(1'b0, "R10 done");
    // R9: partial hardware write aborted
    cmd(8'hBA, "R9 cmd");
    dat(8'h04, "R9 low only");
    cmd(8'hB9, "R9 abort");
    dat(8'h77, "R8 data in read");
    idle(1'b1, "R9 read");
    // R2/R5: full hardware write, ext pull-up set
    cmd(8'hBA, "R2 cmd");
    dat(8'h34, "R2 low");
    dat(8'h12, "R2 high");
    dat(8'h99, "R8 third byte");
    // R10: read with back-pressure
    cmd(8'hBB, "R10 cmd");
    idle(1'b0, "R10 hold1");
    idle(1'b0, "R10 hold2");
    idle(1'b1, "R10 low byte");
    idle(1'b0, "R10 hold high");
    idle(1'b1, "R10 high byte");
    idle(1'b1, "R10 empty");
    // R8: unknown command
    cmd(8'h5A, "R8 unknown");
    dat(8'hFF, "R8 after unknown");
    // R3: suspend patterns
    cmd(8'hB8, "R3 cmd");  dat(8'h20, "R3 set");
    cmd(8'hB8, "R3 cmd");  dat(8'h20, "R3 keep");
    idle(1'b0, "R3 none");
    cmd(8'hB8, "R3 cmd");  dat(8'h08, "R3 clear");
    idle(1'b0, "R3 after");
    cmd(8'hB8, "R3 cmd");  dat(8'h00, "R3 zero again");
    // R4: bus reset pulses
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'hFF, "R4 bus reset");
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, "R4 bus reset");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [7:0] b;
      k = int'($urandom % 10);
      b = 8'($urandom);
      if (k < 3) begin
        logic [7:0] code;
        int s;
        s = int'($urandom % 5);
        code = (s == 0) ? 8'hB8 : (s == 1) ? 8'hB9 : (s == 2) ? 8'hBA : (s == 3) ? 8'hBB : b;
        cyc(1'b1, 1'b1, code, 1'($urandom), ($urandom % 8) == 0, N_IRQ'($urandom % 3 == 0 ? 0 : $urandom), "rand cmd");
      end else if (k < 7) begin
        cyc(1'b1, 1'b0, b, 1'($urandom), ($urandom % 8) == 0, N_IRQ'($urandom % 3 == 0 ? 0 : $urandom), "rand data");
      end else begin
        cyc(1'b0, 1'b0, b, 1'($urandom), ($urandom % 8) == 0, N_IRQ'($urandom % 3 == 0 ? 0 : $urandom), "rand idle");
      end
      if (i == 2000) por("R4 power-on mid run");
    end

    por("R4 final reset");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule